// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block reprograms the divider settings of one PLL without letting its consumers see an unstable clock. A client raises a request that carries three values: the reference divider, the feedback multiplier and the output divider. The sequencer captures them and checks that the resulting VCO frequency and output frequency fall inside the legal windows. An illegal request is turned away with an error status, and nothing on the PLL side changes.

For a legal request the sequencer first moves the consumer clock mux to the slow oscillator bypass. It then asserts the PLL reset and, with reset held, writes the minus-one encoded divider fields and the derived loop bandwidth field. Reset is released after a timed hold. The lock input is then sampled once per microsecond. The mux goes back to normal mode only when lock is seen. If lock never arrives within the timeout window, the sequencer ends with a timeout status and the PLL stays in slow mode.

The analog PLL is not part of the block. Its lock output arrives on `lock_i`. The time base is the core clock, scaled by a cycles-per-microsecond parameter.

Top module: `pll_prog_seq`

## Requirements
- R1: `mode_o` reads 0 (slow bypass) from reset and is set to 0 one cycle after a legal request is accepted. It becomes 1 (normal) only on a lock sample that found `lock_i` high, and it is 0 whenever `pll_rst_o` is high.
- R2: `pll_rst_o` rises two clock edges after acceptance. The divider fields change one edge later and only while `pll_rst_o` is high.
- R3: `pll_rst_o` stays high for at least RST_HOLD_US × CYC_PER_US cycles. Exactly that many cycles plus one pass from its rise to its fall.
- R4: Field encodings are as follows. `ref_div_fld_o` (6 bits) is the reference divider minus 1. `out_div_fld_o` (4 bits) is the output divider minus 1. `fb_mul_fld_o` (13 bits) is the feedback multiplier minus 1. `bw_fld_o` (12 bits) is (feedback multiplier shifted right by one) minus 1.
- R5: A request is legal only if all of the following hold. The reference divider is 1..64, the feedback multiplier is 2..8192, and the output divider is 1..16 and either 1 or even. REF_KHZ × mult / refdiv lies within 440000..2200000 kHz inclusive. That VCO value divided by the output divider lies within 27500..2200000 kHz inclusive.
- R6: An illegal request is acknowledged two edges after acceptance (the accept edge counted as the first) with `status_o` = 1. Mode, reset and all fields keep their previous values.
- R7: The first lock sample falls CYC_PER_US cycles after reset release, and each later sample follows CYC_PER_US cycles after the one before. A lock that rises between samples is acted on at the next sample.
- R8: If LOCK_TMO_US samples in a row find `lock_i` low, `ack_o` pulses with `status_o` = 2, `mode_o` stays 0 and `pll_rst_o` stays low. A later request works normally.
- R9: `ack_o` is a one-cycle pulse. A legal request whose lock is already present at the first sample is acknowledged with `status_o` = 0 on the edge 3 + RST_HOLD_US × CYC_PER_US + CYC_PER_US edges after the accept edge.
- R10: Divider inputs are captured on the accept edge, and only while idle. Changes to them during a running sequence have no effect on the fields written or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, held until `ack_o` |
| ref_div_i | input | 7 | Requested reference divider |
| fb_mul_i | input | 14 | Requested feedback multiplier |
| out_div_i | input | 5 | Requested output divider |
| ack_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome: 0 done, 1 illegal, 2 lock timeout |
| ref_div_fld_o | output | 6 | Encoded reference divider field |
| fb_mul_fld_o | output | 13 | Encoded feedback field |
| out_div_fld_o | output | 4 | Encoded output divider field |
| bw_fld_o | output | 12 | Derived bandwidth adjust field |
| pll_rst_o | output | 1 | PLL reset |
| mode_o | output | 2 | Consumer mux mode: 0 slow, 1 normal |
| lock_i | input | 1 | PLL lock status |

## Verification
Every result lands on a fixed edge counted from the accept edge. Slow mode appears on edge 2, reset rises on edge 3 and the fields change on edge 4. The acknowledge comes on edge 2 for an illegal request. With the bench settings of 4 cycles per microsecond, a 10 µs hold and a 20-sample timeout, it comes on edge 48 after an immediate lock and on edge 124 after a timeout. Lock raised partway through the wait moves the acknowledge to the first microsecond sample after the rise. The bench counts edges from the request and reads every output at the falling edge that follows, so each value is seen after its register has updated. Latency, the first edge of each change and the reset length are compared against these exact expected numbers.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int REF_DIV_FW = 6;
    localparam int OUT_DIV_FW = 4;
    localparam int FB_MUL_FW  = 13;
    localparam int BW_FW      = 12;

    localparam int REF_DIV_IW = REF_DIV_FW + 1;
    localparam int OUT_DIV_IW = OUT_DIV_FW + 1;
    localparam int FB_MUL_IW  = FB_MUL_FW + 1;

    typedef struct packed {
        logic [REF_DIV_IW-1:0] ref_div;
        logic [FB_MUL_IW-1:0]  fb_mul;
        logic [OUT_DIV_IW-1:0] out_div;
    } pll_req_t;

    typedef struct packed {
        logic [REF_DIV_FW-1:0] ref_div_f;
        logic [FB_MUL_FW-1:0]  fb_mul_f;
        logic [OUT_DIV_FW-1:0] out_div_f;
        logic [BW_FW-1:0]      bw_f;
    } pll_fld_t;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1
    } pll_mode_e;

    typedef enum logic [1:0] {
        STS_OK      = 2'd0,
        STS_ILLEGAL = 2'd1,
        STS_TIMEOUT = 2'd2
    } seq_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RST_ON,
        S_WRITE,
        S_HOLD,
        S_WAIT_LOCK
    } seq_state_e;

endpackage

// File: rtl/pll_legal_chk.sv
module pll_legal_chk
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int OUT_MAX_KHZ = 2200000
) (
    input  pll_req_t req_i,
    output logic     legal_o
);
    localparam int PW = 48;

    logic [PW-1:0] vco_num;
    logic [PW-1:0] vco_lo;
    logic [PW-1:0] vco_hi;
    logic [PW-1:0] div_prod;
    logic [PW-1:0] out_lo;
    logic [PW-1:0] out_hi;
    logic          range_ok;
    logic          parity_ok;
    logic          vco_ok;
    logic          out_ok;

    always_comb begin
        // Ratios compared by cross-multiplying, so no divider is needed
        vco_num  = PW'(REF_KHZ) * PW'(req_i.fb_mul);
        vco_lo   = PW'(VCO_MIN_KHZ) * PW'(req_i.ref_div);
        vco_hi   = PW'(VCO_MAX_KHZ) * PW'(req_i.ref_div);
        div_prod = PW'(req_i.ref_div) * PW'(req_i.out_div);
        out_lo   = PW'(OUT_MIN_KHZ) * div_prod;
        out_hi   = PW'(OUT_MAX_KHZ) * div_prod;

        range_ok = (req_i.ref_div != '0)
                && (req_i.ref_div <= REF_DIV_IW'(1 << REF_DIV_FW))
                && (req_i.fb_mul >= FB_MUL_IW'(2))
                && (req_i.fb_mul <= FB_MUL_IW'(1 << FB_MUL_FW))
                && (req_i.out_div != '0)
                && (req_i.out_div <= OUT_DIV_IW'(1 << OUT_DIV_FW));
        parity_ok = (req_i.out_div == OUT_DIV_IW'(1)) || !req_i.out_div[0];
        vco_ok    = (vco_num >= vco_lo) && (vco_num <= vco_hi);
        out_ok    = (vco_num >= out_lo) && (vco_num <= out_hi);
        legal_o   = range_ok && parity_ok && vco_ok && out_ok;
    end

endmodule

// File: rtl/pll_field_enc.sv
module pll_field_enc
    import pll_seq_pkg::*;
(
    input  pll_req_t req_i,
    output pll_fld_t fld_o
);
    logic [FB_MUL_IW-1:0] half_mul;

    always_comb begin
        half_mul        = req_i.fb_mul >> 1;
        fld_o.ref_div_f = REF_DIV_FW'(req_i.ref_div - 1'b1);
        fld_o.fb_mul_f  = FB_MUL_FW'(req_i.fb_mul - 1'b1);
        fld_o.out_div_f = OUT_DIV_FW'(req_i.out_div - 1'b1);
        fld_o.bw_f      = BW_FW'(half_mul - 1'b1);
    end

endmodule

// File: rtl/pll_us_tick.sv
module pll_us_tick #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

    generate
        if (CYC_PER_US > 1) begin : g_spacing
            AST_TICK_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
                $rose(en_i) |-> !tick_o); // R7
        end
    endgenerate

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_KHZ     = 24000,
    parameter int CYC_PER_US  = 100,
    parameter int RST_HOLD_US = 10,
    parameter int LOCK_TMO_US = 1000,
    parameter int VCO_MIN_KHZ = 440000,
    parameter int VCO_MAX_KHZ = 2200000,
    parameter int OUT_MIN_KHZ = 27500,
    parameter int OUT_MAX_KHZ = 2200000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [6:0]  ref_div_i,
    input  logic [13:0] fb_mul_i,
    input  logic [4:0]  out_div_i,
    output logic        ack_o,
    output logic [1:0]  status_o,
    output logic [5:0]  ref_div_fld_o,
    output logic [12:0] fb_mul_fld_o,
    output logic [3:0]  out_div_fld_o,
    output logic [11:0] bw_fld_o,
    output logic        pll_rst_o,
    output logic [1:0]  mode_o,
    input  logic        lock_i
);
    localparam int HOLD_CYC = RST_HOLD_US * CYC_PER_US;
    localparam int HW       = $clog2(HOLD_CYC + 2);
    localparam int TW       = $clog2(LOCK_TMO_US + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(LOCK_TMO_US - 1);

    seq_state_e  state_q;
    pll_req_t    req_q;
    pll_fld_t    fld_q;
    pll_fld_t    fld_enc;
    pll_mode_e   mode_q;
    seq_status_e status_q;
    logic        ack_q;
    logic        rst_q;
    logic        legal;
    logic        us_tick;
    logic [HW-1:0] hold_cnt_q;
    logic [TW-1:0] tmo_cnt_q;

    pll_legal_chk #(
        .REF_KHZ     (REF_KHZ),
        .VCO_MIN_KHZ (VCO_MIN_KHZ),
        .VCO_MAX_KHZ (VCO_MAX_KHZ),
        .OUT_MIN_KHZ (OUT_MIN_KHZ),
        .OUT_MAX_KHZ (OUT_MAX_KHZ)
    ) u_legal (
        .req_i   (req_q),
        .legal_o (legal)
    );

    pll_field_enc u_enc (
        .req_i (req_q),
        .fld_o (fld_enc)
    );

    pll_us_tick #(
        .CYC_PER_US (CYC_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (state_q == S_WAIT_LOCK),
        .tick_o (us_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            req_q      <= '0;
            fld_q      <= '0;
            mode_q     <= MODE_SLOW;
            status_q   <= STS_OK;
            ack_q      <= 1'b0;
            rst_q      <= 1'b0;
            hold_cnt_q <= '0;
            tmo_cnt_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_i) begin
                        req_q.ref_div <= ref_div_i;
                        req_q.fb_mul  <= fb_mul_i;
                        req_q.out_div <= out_div_i;
                        state_q       <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (legal) begin
                        mode_q  <= MODE_SLOW;
                        state_q <= S_RST_ON;
                    end else begin
                        ack_q    <= 1'b1;
                        status_q <= STS_ILLEGAL;
                        state_q  <= S_IDLE;
                    end
                end
                S_RST_ON: begin
                    rst_q   <= 1'b1;
                    state_q <= S_WRITE;
                end
                S_WRITE: begin
                    fld_q      <= fld_enc;
                    hold_cnt_q <= '0;
                    state_q    <= S_HOLD;
                end
                S_HOLD: begin
                    if (hold_cnt_q == HOLD_LAST) begin
                        rst_q     <= 1'b0;
                        tmo_cnt_q <= '0;
                        state_q   <= S_WAIT_LOCK;
                    end else begin
                        hold_cnt_q <= hold_cnt_q + 1'b1;
                    end
                end
                S_WAIT_LOCK: begin
                    if (us_tick) begin
                        if (lock_i) begin
                            mode_q   <= MODE_NORMAL;
                            ack_q    <= 1'b1;
                            status_q <= STS_OK;
                            state_q  <= S_IDLE;
                        end else if (tmo_cnt_q == TMO_LAST) begin
                            ack_q    <= 1'b1;
                            status_q <= STS_TIMEOUT;
                            state_q  <= S_IDLE;
                        end else begin
                            tmo_cnt_q <= tmo_cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign ack_o         = ack_q;
    assign status_o      = status_q;
    assign ref_div_fld_o = fld_q.ref_div_f;
    assign fb_mul_fld_o  = fld_q.fb_mul_f;
    assign out_div_fld_o = fld_q.out_div_f;
    assign bw_fld_o      = fld_q.bw_f;
    assign pll_rst_o     = rst_q;
    assign mode_o        = mode_q;

    // Length of the current reset pulse, watched at the ports
    logic [HW-1:0] rst_run_q;
    always_ff @(posedge clk) begin
        if (rst || !pll_rst_o) begin
            rst_run_q <= '0;
        end else if (rst_run_q != {HW{1'b1}}) begin
            rst_run_q <= rst_run_q + 1'b1;
        end
    end

    AST_SLOW_WHILE_RESET: assert property (@(posedge clk) disable iff (rst)
        pll_rst_o |-> (mode_o == MODE_SLOW)); // R1
    AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == MODE_NORMAL) && ($past(mode_o) != MODE_NORMAL)) |-> $past(lock_i)); // R1
    AST_FIELDS_UNDER_RESET: assert property (@(posedge clk) disable iff (rst)
        !$stable({ref_div_fld_o, fb_mul_fld_o, out_div_fld_o, bw_fld_o}) |-> pll_rst_o); // R2
    AST_RESET_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_rst_o) |-> (rst_run_q >= HW'(HOLD_CYC))); // R3
    AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (ack_o && (status_o == STS_ILLEGAL)) |-> ($stable(mode_o) && !pll_rst_o)); // R6
    AST_TIMEOUT_STAYS_SLOW: assert property (@(posedge clk) disable iff (rst)
        (ack_o && (status_o == STS_TIMEOUT)) |-> ((mode_o == MODE_SLOW) && !pll_rst_o)); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R9

endmodule

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 4;
    localparam int HOLD_US    = 10;
    localparam int TMO_US     = 20;
    localparam int HOLD       = HOLD_US * CYC;
    localparam int LAT_OK     = 3 + HOLD + CYC + 1;
    localparam int LAT_ILL    = 2;
    localparam int LAT_TMO    = 3 + HOLD + CYC * TMO_US + 1;

    logic        clk;
    logic        rst;
    logic        req_i;
    logic [6:0]  ref_div_i;
    logic [13:0] fb_mul_i;
    logic [4:0]  out_div_i;
    logic        ack_o;
    logic [1:0]  status_o;
    logic [5:0]  ref_div_fld_o;
    logic [12:0] fb_mul_fld_o;
    logic [3:0]  out_div_fld_o;
    logic [11:0] bw_fld_o;
    logic        pll_rst_o;
    logic [1:0]  mode_o;
    logic        lock_i;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    int lock_after = 0;
    int since_rel = 0;

    pll_prog_seq #(
        .REF_KHZ     (24000),
        .CYC_PER_US  (CYC),
        .RST_HOLD_US (HOLD_US),
        .LOCK_TMO_US (TMO_US)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req_i),
        .ref_div_i     (ref_div_i),
        .fb_mul_i      (fb_mul_i),
        .out_div_i     (out_div_i),
        .ack_o         (ack_o),
        .status_o      (status_o),
        .ref_div_fld_o (ref_div_fld_o),
        .fb_mul_fld_o  (fb_mul_fld_o),
        .out_div_fld_o (out_div_fld_o),
        .bw_fld_o      (bw_fld_o),
        .pll_rst_o     (pll_rst_o),
        .mode_o        (mode_o),
        .lock_i        (lock_i)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // PLL lock model: lock rises lock_after+1 falling edges after reset release
    always @(negedge clk) begin
        if (pll_rst_o) begin
            since_rel = 0;
            lock_i = 1'b0;
        end else begin
            since_rel++;
            lock_i = (lock_after >= 0) && (since_rel > lock_after);
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc_cnt, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_fields(input string tag, input int rd, input int fm, input int od);
        chk(tag, "ref_div field", int'(ref_div_fld_o), rd - 1);
        chk(tag, "fb_mul field", int'(fb_mul_fld_o), fm - 1);
        chk(tag, "out_div field", int'(out_div_fld_o), od - 1);
        chk(tag, "bw field", int'(bw_fld_o), (fm >> 1) - 1);
    endtask

    // Drive one request and observe the ports at every falling edge until ack
    task automatic do_req(input int rd, input int fm, input int od, input bit scramble,
                          output int lat, output int st, output int rst_len,
                          output int slow_at, output int rst_at, output int fld_at,
                          output int norm_at);
        logic [34:0] prev_f;
        logic        prev_r;
        @(negedge clk);
        ref_div_i = 7'(rd);
        fb_mul_i  = 14'(fm);
        out_div_i = 5'(od);
        req_i     = 1'b1;
        prev_f  = {ref_div_fld_o, fb_mul_fld_o, out_div_fld_o, bw_fld_o};
        prev_r  = pll_rst_o;
        lat = 0; st = -1; rst_len = 0;
        slow_at = -1; rst_at = -1; fld_at = -1; norm_at = -1;
        while (lat < 2000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (scramble && lat == 1) begin
                ref_div_i = '0;
                fb_mul_i  = '0;
                out_div_i = '0;
            end
            if (mode_o == 2'd0 && slow_at < 0) slow_at = lat;
            if (mode_o == 2'd1 && slow_at >= 0 && norm_at < 0) norm_at = lat;
            if (pll_rst_o && !prev_r && rst_at < 0) rst_at = lat;
            if ({ref_div_fld_o, fb_mul_fld_o, out_div_fld_o, bw_fld_o} != prev_f && fld_at < 0)
                fld_at = lat;
            if (pll_rst_o) rst_len++;
            prev_r = pll_rst_o;
            if (ack_o) begin
                st = int'(status_o);
                break;
            end
        end
        req_i = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R9", "ack after reset", int'(ack_o), 0);
        chk("R9", "status after reset", int'(status_o), 0);
        chk("R1", "mode after reset", int'(mode_o), 0);
        chk("R2", "pll reset after reset", int'(pll_rst_o), 0);
        chk("R4", "fields after reset",
            int'({ref_div_fld_o, fb_mul_fld_o, out_div_fld_o, bw_fld_o} != 0), 0);
    endtask

    task automatic t_first_program();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(1, 50, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R9", "latency immediate lock", lat, LAT_OK);
        chk("R9", "status ok", st, 0);
        chk("R2", "reset rise edge", ra, 3);
        chk("R2", "field write edge", fa, 4);
        chk("R3", "reset high cycles", rl, HOLD + 1);
        chk("R1", "normal edge", na, LAT_OK);
        chk("R1", "mode at end", int'(mode_o), 1);
        chk_fields("R4", 1, 50, 1);
    endtask

    task automatic t_second_program();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(9, 400, 2, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R1", "slow edge from normal", sa, 2);
        chk("R2", "reset rise edge", ra, 3);
        chk("R2", "field write edge", fa, 4);
        chk("R1", "normal edge", na, LAT_OK);
        chk("R9", "status ok", st, 0);
        chk_fields("R4", 9, 400, 2);
    endtask

    task automatic t_vco_window();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(3, 55, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "vco exactly 440 MHz status", st, 0);
        chk_fields("R5", 3, 55, 1);
        do_req(3, 275, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "vco exactly 2200 MHz status", st, 0);
        chk_fields("R5", 3, 275, 1);
        do_req(3, 276, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "vco above max status", st, 1);
        chk("R5", "vco above max latency", lat, LAT_ILL);
        do_req(1, 18, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "vco below min status", st, 1);
    endtask

    task automatic t_divider_ranges();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(1, 50, 3, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "odd output divider status", st, 1);
        do_req(1, 50, 16, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "output divider 16 status", st, 0);
        chk_fields("R5", 1, 50, 16);
        do_req(3, 55, 16, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "output exactly 27.5 MHz status", st, 0);
        do_req(1, 50, 0, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "zero output divider status", st, 1);
        do_req(0, 50, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "zero reference divider status", st, 1);
        do_req(65, 2000, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "reference divider 65 status", st, 1);
        do_req(64, 1200, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R5", "reference divider 64 status", st, 0);
        chk_fields("R5", 64, 1200, 1);
    endtask

    task automatic t_illegal_no_effect();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(1, 50, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        do_req(1, 50, 5, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R6", "illegal status", st, 1);
        chk("R6", "illegal latency", lat, LAT_ILL);
        chk("R6", "mode kept", int'(mode_o), 1);
        chk("R6", "reset pulses", rl, 0);
        chk("R6", "field change edge", fa, -1);
        chk_fields("R6", 1, 50, 1);
    endtask

    task automatic t_lock_sampling();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 3;
        do_req(2, 100, 2, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R7", "lock just before first sample", lat, LAT_OK);
        lock_after = 4;
        do_req(2, 110, 2, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R7", "lock missing first sample", lat, LAT_OK + CYC);
        lock_after = 10;
        do_req(2, 120, 2, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R7", "lock at third sample", lat, LAT_OK + 2 * CYC);
        chk("R1", "normal only at lock sample", na, LAT_OK + 2 * CYC);
        chk("R7", "status", st, 0);
        lock_after = 0;
    endtask

    task automatic t_timeout();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = -1;
        do_req(1, 60, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R8", "timeout latency", lat, LAT_TMO);
        chk("R8", "timeout status", st, 2);
        chk("R8", "mode after timeout", int'(mode_o), 0);
        chk("R8", "reset after timeout", int'(pll_rst_o), 0);
        chk("R8", "normal never reached", na, -1);
        lock_after = 0;
        do_req(1, 70, 1, 1'b0, lat, st, rl, sa, ra, fa, na);
        chk("R8", "recovery status", st, 0);
        chk("R8", "recovery mode", int'(mode_o), 1);
        @(negedge clk);
        chk("R9", "ack one cycle", int'(ack_o), 0);
    endtask

    task automatic t_capture();
        int lat, st, rl, sa, ra, fa, na;
        lock_after = 0;
        do_req(2, 90, 4, 1'b1, lat, st, rl, sa, ra, fa, na);
        chk("R10", "status with changed inputs", st, 0);
        chk("R10", "latency with changed inputs", lat, LAT_OK);
        chk_fields("R10", 2, 90, 4);
    endtask

    initial begin
        rst       = 1'b1;
        req_i     = 1'b0;
        ref_div_i = '0;
        fb_mul_i  = '0;
        out_div_i = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_first_program();
        t_second_program();
        t_vco_window();
        t_divider_ranges();
        t_illegal_no_effect();
        t_lock_sampling();
        t_timeout();
        t_capture();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule